// File: doc/BRIEF.md
# Single-Channel Bus-Request DMA Controller

This block moves a programmed block of data units between one peripheral and memory without CPU involvement. Software loads a 16-bit start address, a 16-bit count holding the number of units minus one, and a control word. The control word picks the direction, the unit size and the ownership policy, and it arms the channel. While the channel is armed, it requests the system bus whenever the peripheral asks for service. Once the bus is granted, it drives the memory address together with a read or write strobe and acknowledges the peripheral. When the last unit has moved, it raises a sticky interrupt.

Two ownership policies are available. In burst mode the bus is held from the first grant until the whole block is done. In cycle-stealing mode the bus is given back after every unit, and a fresh grant is obtained for the next one. The address steps by one or two per unit and wraps inside its 64 kB segment.

The state machine has four states. IDLE → REQUEST when the channel is armed, data request is high and bus grant is low. REQUEST → MOVE when grant and data request are both high. MOVE → REQUEST for a non-final unit in burst mode. MOVE → LEAVE for the final unit, or for any unit in cycle-stealing mode. LEAVE → IDLE always.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The register port decodes `cpu_sel` as follows: 0 is the address, 1 is the count, 2 is control and 3 is status. Control bits are: bit0 arm (go), bit1 direction (1 = memory-to-device, which uses `mem_rd`; 0 = device-to-memory, which uses `mem_wr`), bit2 mode (1 = cycle stealing, 0 = burst), bit3 unit size (1 = two bytes). Status bit0 is the done flag. All registers read back on `cpu_rdata`, with unused bits at zero.
- R2: While the arm bit is set, writes to any register are ignored.
- R3: `bus_req` rises only after a cycle in which the channel was armed, `dreq` was high and `bus_grant` was low.
- R4: A unit is one cycle with `dack` high and exactly one strobe high, and it happens only while `bus_grant` is high. The direction bit selects the strobe.
- R5: After each unit the address advances by 1, or by 2 when the unit-size bit is set, modulo 65536. It never carries beyond 16 bits. `mem_wide` shows the unit-size bit.
- R6: A count of N−1 yields exactly N units. After the final unit the count reads 0xFFFF.
- R7: In burst mode `bus_req` stays high from its rise until after the final unit, including while `dreq` is low in mid-block.
- R8: In cycle-stealing mode `bus_req` falls after every unit, so each unit has its own request.
- R9: `bus_req` falls only one cycle after the last strobe, never in the same cycle as a strobe.
- R10: The final unit clears the arm bit and sets done, which drives `irq`. Done stays set until a control write clears it.
- R11: After reset, `bus_req`, `dack`, the strobes and `irq` are low, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 2 | Register select |
| cpu_we | input | 1 | Register write enable |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| dreq | input | 1 | Peripheral data request |
| dack | output | 1 | Peripheral data acknowledge |
| mem_addr | output | 16 | Memory address of the current unit |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wide | output | 1 | High when the unit is two bytes |
| irq | output | 1 | Block-complete interrupt |

## Verification
A wrong state or a wrong transition shows on `bus_req` or on a strobe in the very next cycle. Examples are a skipped LEAVE, a burst that drops the bus, or a request made without `dreq`. The reference model compares these outputs every clock, so such faults are caught immediately. A wrong address or count value appears on `mem_addr` at the next unit, and at the latest in the final readback of address, count and status once the block ends.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_MOVE  = 2'd2,
        ST_LEAVE = 2'd3
    } dmac_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_ADDR = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CNT  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd3;

    localparam int CTRL_W = 4;

    typedef struct packed {
        logic wide;   // bit3: two-byte unit
        logic steal;  // bit2: cycle-stealing mode
        logic dir;    // bit1: memory-to-device
        logic go;     // bit0: armed
    } dmac_ctrl_t;
endpackage

// File: rtl/dmac_counters.sv
module dmac_counters #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              step,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              cnt_zero
);
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  CNT_ONE     = CNT_W'(1);

    logic [ADDR_W-1:0] addr_inc;

    // Sum is truncated to ADDR_W bits, so the address wraps inside its segment.
    assign addr_inc = addr_q + (wide ? STEP_WIDE : STEP_NARROW);
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_addr) begin
            addr_q <= addr_wdata;
        end else if (step) begin
            addr_q <= addr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_cnt) begin
            cnt_q <= cnt_wdata;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // R2: a register load and a unit step never coincide.
    p_no_load_during_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !ld_addr && !ld_cnt);
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              last_unit,
    output dmac_ctrl_t        ctrl,
    output logic              done,
    output logic              ld_addr,
    output logic              ld_cnt,
    output logic [DATA_W-1:0] cpu_rdata
);
    logic wr_ok;
    logic ld_ctrl;

    assign wr_ok   = cpu_we && !ctrl.go;
    assign ld_addr = wr_ok && (cpu_sel == SEL_ADDR);
    assign ld_cnt  = wr_ok && (cpu_sel == SEL_CNT);
    assign ld_ctrl = wr_ok && (cpu_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            done <= 1'b0;
        end else if (ld_ctrl) begin
            ctrl <= dmac_ctrl_t'(cpu_wdata[CTRL_W-1:0]);
            done <= 1'b0;
        end else if (last_unit) begin
            ctrl.go <= 1'b0;
            done    <= 1'b1;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_sel)
            SEL_ADDR: cpu_rdata = DATA_W'(addr_q);
            SEL_CNT:  cpu_rdata = DATA_W'(cnt_q);
            SEL_CTRL: cpu_rdata = DATA_W'(ctrl);
            SEL_STAT: cpu_rdata = DATA_W'(done);
            default:  cpu_rdata = '0;
        endcase
    end

    // R10: done stays set until a control write.
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(cpu_we && cpu_sel == SEL_CTRL)) |=> done);
    // R10: the arm bit only drops together with done being raised.
    p_go_clear_sets_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.go) |-> done);
endmodule

// File: rtl/dmac_fsm.sv
module dmac_fsm
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic steal,
    input  logic dir,
    input  logic bus_grant,
    input  logic dreq,
    input  logic cnt_zero,
    output logic bus_req,
    output logic dack,
    output logic mem_rd,
    output logic mem_wr,
    output logic step,
    output logic last_unit
);
    dmac_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && dreq && !bus_grant) state_d = ST_REQ;
            ST_REQ:   if (bus_grant && dreq)        state_d = ST_MOVE;
            ST_MOVE:  state_d = (cnt_zero || steal) ? ST_LEAVE : ST_REQ;
            ST_LEAVE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req = 1'b0;
        dack    = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   bus_req = 1'b1;
            ST_MOVE: begin
                bus_req = 1'b1;
                dack    = 1'b1;
                step    = 1'b1;
                mem_rd  = dir;
                mem_wr  = !dir;
            end
            ST_LEAVE: bus_req = 1'b1;
            default:  ;
        endcase
    end

    assign last_unit = step && cnt_zero;

    // R3: a new request needs an armed channel, an active request and no grant.
    p_req_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(go) && $past(dreq) && !$past(bus_grant));
    // R4: strobes only under grant.
    p_strobe_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_grant);
    // R7: burst keeps the bus after a non-final unit.
    p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !steal && !cnt_zero) |=> bus_req);
    // R8: cycle stealing gives the bus back after each unit.
    p_steal_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && steal) |=> ##1 !bus_req);
    // R9: strobes are already low in the cycle before the request falls.
    p_strobe_before_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> !$past(mem_rd) && !$past(mem_wr));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              dreq,
    output logic              dack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wide,
    output logic              irq
);
    dmac_ctrl_t        ctrl;
    logic              done;
    logic              ld_addr;
    logic              ld_cnt;
    logic              step;
    logic              last_unit;
    logic              cnt_zero;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    dmac_ctrl_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_sel  (cpu_sel),
        .cpu_we   (cpu_we),
        .cpu_wdata(cpu_wdata),
        .addr_q   (addr_q),
        .cnt_q    (cnt_q),
        .last_unit(last_unit),
        .ctrl     (ctrl),
        .done     (done),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_cnt),
        .cpu_rdata(cpu_rdata)
    );

    dmac_counters #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .addr_wdata(cpu_wdata[ADDR_W-1:0]),
        .cnt_wdata (cpu_wdata[CNT_W-1:0]),
        .step      (step),
        .wide      (ctrl.wide),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .cnt_zero  (cnt_zero)
    );

    dmac_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (ctrl.go),
        .steal    (ctrl.steal),
        .dir      (ctrl.dir),
        .bus_grant(bus_grant),
        .dreq     (dreq),
        .cnt_zero (cnt_zero),
        .bus_req  (bus_req),
        .dack     (dack),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .step     (step),
        .last_unit(last_unit)
    );

    assign mem_addr = addr_q;
    assign mem_wide = ctrl.wide;
    assign irq      = done;

    // R4: acknowledge and strobe travel together.
    p_dack_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> (mem_rd ^ mem_wr));
endmodule

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;
    logic        bus_req, bus_grant = 1'b0, dreq = 1'b0, dack;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, mem_wide, irq;

    int checks = 0, errors = 0, cyc = 0;
    int rises = 0, n_rd = 0, n_wr = 0;
    logic prev_req = 1'b0;
    bit finished = 0;

    // reference model state
    int          m_st = 0;
    bit          m_go = 0, m_done = 0, m_steal = 0, m_dir = 0, m_wide = 0, g0 = 0;
    logic [15:0] m_addr = 16'd0, m_cnt = 16'd0;

    always #4 clk = ~clk;  // 125 MHz

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide), .irq(irq));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // behavioural reference, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_go = 0; m_done = 0; m_steal = 0; m_dir = 0; m_wide = 0;
            m_addr = 0; m_cnt = 0;
        end else begin
            g0 = m_go;
            case (m_st)
                0: if (m_go && dreq && !bus_grant) m_st = 1;
                1: if (bus_grant && dreq) m_st = 2;
                2: begin
                    m_addr = m_addr + (m_wide ? 16'd2 : 16'd1);
                    if (m_cnt == 16'd0) begin m_done = 1; m_go = 0; m_st = 3; end
                    else m_st = m_steal ? 3 : 1;
                    m_cnt = m_cnt - 16'd1;
                end
                default: m_st = 0;
            endcase
            if (cpu_we && !g0) begin
                case (cpu_sel)
                    2'd0: m_addr = cpu_wdata;
                    2'd1: m_cnt = cpu_wdata;
                    2'd2: begin
                        m_go = cpu_wdata[0]; m_dir = cpu_wdata[1];
                        m_steal = cpu_wdata[2]; m_wide = cpu_wdata[3]; m_done = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // CPU side: grant follows request with one cycle of latency
    always @(negedge clk) bus_grant <= rst_n ? bus_req : 1'b0;

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R7/R8/R9", "bus_req", bus_req, m_st != 0);
            chk("R4", "mem_rd", mem_rd, m_st == 2 && m_dir);
            chk("R4", "mem_wr", mem_wr, m_st == 2 && !m_dir);
            chk("R4", "dack", dack, m_st == 2);
            chk("R10", "irq", irq, m_done);
            chk("R5", "mem_wide", mem_wide, m_wide);
            if (m_st == 2) chk("R5", "mem_addr", mem_addr, m_addr);
            if (bus_req && !prev_req) rises++;
            if (mem_rd) n_rd++;
            if (mem_wr) n_wr++;
            prev_req = bus_req;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            summary();
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); cpu_sel = sel; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk); cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk); cpu_sel = sel; #1 d = cpu_rdata;
    endtask

    task automatic wait_irq();
        while (irq !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_stats();
        rises = 0; n_rd = 0; n_wr = 0;
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "bus_req", bus_req, 0);
        chk("R11", "irq", irq, 0);
        chk("R11", "strobes", {mem_rd, mem_wr, dack}, 0);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v); chk("R11", "reg after reset", v, 0);
        end

        // R1 control readback without arming
        wr(2'd2, 16'h000E);
        rd(2'd2, v); chk("R1", "ctrl readback", v, 16'h000E);
        rd(2'd3, v); chk("R1", "status", v, 0);

        // Burst, device-to-memory, byte units, 4 units
        dreq = 1'b1;
        wr(2'd0, 16'h1000); wr(2'd1, 16'd3);
        rd(2'd0, v); chk("R1", "addr readback", v, 16'h1000);
        rd(2'd1, v); chk("R1", "count readback", v, 16'd3);
        clear_stats();
        wr(2'd2, 16'h0001);
        wait_irq();
        chk("R7", "burst request count", rises, 1);
        chk("R6", "units moved", n_wr, 4);
        chk("R4", "no reads in write direction", n_rd, 0);
        rd(2'd0, v); chk("R5", "final addr", v, 16'h1004);
        rd(2'd1, v); chk("R6", "count after end", v, 16'hFFFF);
        rd(2'd3, v); chk("R10", "done", v, 1);
        rd(2'd2, v); chk("R10", "go cleared", v, 0);
        repeat (4) @(negedge clk);
        chk("R10", "irq sticky", irq, 1);
        wr(2'd2, 16'h0000);
        chk("R10", "irq cleared", irq, 0);

        // Cycle stealing, memory-to-device, word units, segment wrap
        wr(2'd0, 16'hFFFC); wr(2'd1, 16'd2);
        clear_stats();
        wr(2'd2, 16'h000F);
        wait_irq();
        chk("R8", "one request per unit", rises, 3);
        chk("R4", "reads", n_rd, 3);
        chk("R4", "writes", n_wr, 0);
        rd(2'd0, v); chk("R5", "word wrap addr", v, 16'h0002);
        wr(2'd2, 16'h0000);

        // Request gating by dreq, writes ignored while armed
        dreq = 1'b0;
        wr(2'd0, 16'h0200); wr(2'd1, 16'd0);
        clear_stats();
        wr(2'd2, 16'h0005);
        wr(2'd0, 16'h0ABC); wr(2'd1, 16'd5); wr(2'd2, 16'h0000);
        repeat (8) @(negedge clk);
        chk("R3", "no request without dreq", rises, 0);
        rd(2'd0, v); chk("R2", "addr write ignored", v, 16'h0200);
        rd(2'd1, v); chk("R2", "count write ignored", v, 16'd0);
        rd(2'd2, v); chk("R2", "ctrl write ignored", v, 16'h0005);
        dreq = 1'b1;
        wait_irq();
        chk("R6", "single unit", n_wr, 1);
        rd(2'd0, v); chk("R5", "byte step", v, 16'h0201);
        wr(2'd2, 16'h0000);

        // Burst with a mid-block dreq pause, byte wrap
        wr(2'd0, 16'hFFFE); wr(2'd1, 16'd3);
        clear_stats();
        wr(2'd2, 16'h0003);
        while (n_rd < 2) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7", "bus held during pause", bus_req, 1);
        dreq = 1'b1;
        wait_irq();
        chk("R7", "single request in burst", rises, 1);
        chk("R6", "units in paused burst", n_rd, 4);
        rd(2'd0, v); chk("R5", "byte wrap addr", v, 16'h0002);
        wr(2'd2, 16'h0000);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule